// File: doc/BRIEF.md
# Fast Ethernet Receive Symbol Decoder

This block turns a recovered 100 Mb/s line stream into receive nibbles for a media access controller. Each bit time it takes one three-level line symbol, marked by a bit strobe, from the clock and data recovery stage. It converts level changes to NRZI and then to NRZ. The NRZ stream is unscrambled with an 11-bit keystream generator. The block then finds the 5-bit code-group boundary at the start-of-stream delimiter and maps each code group back to a data nibble.

The keystream generator starts with no knowledge of the far end's state. While the link carries idle, every unscrambled bit is a one, so each received bit reveals one keystream bit. The generator loads those bits until it predicts a long run of them correctly, and it then runs freely. Frames are decoded only while the descrambler holds lock. Lock is dropped when no idle run has been seen for a programmable number of bit times, and it is then acquired again from the next idle.

Top module: `fe_rx_decoder`

## Requirements
- R1: While reset is asserted, and until the first frame is decoded, `rx_dv`, `rx_er`, `rx_nib_valid` and `rxd` are all zero.
- R2: On `sym_level`, 2'b00 and 2'b10 both mean the zero level, 2'b01 means positive and 2'b11 means negative. A level that differs from the previous strobed level is an NRZI one. An NRZI value that differs from the previous NRZI value is an NRZ one.
- R3: The keystream follows k[n] = k[n-11] XOR k[n-9]. Each unscrambled bit is the NRZ bit XOR the keystream bit.
- R4: Before lock, the inverted NRZ bit is shifted into the keystream register. Lock is declared after LOCK_RUN (default 60) consecutive inverted bits match the register's prediction. No nibble and no `rx_dv` appear while unlocked.
- R5: While locked, lock is dropped if LOSS_BITS bit times (default 250000, about 2 ms) pass without IDLE_RUN (default 20) consecutive unscrambled ones. Nothing is decoded until lock is acquired again.
- R6: In the hunt state, a frame starts when the last ten unscrambled bits equal 11000 10001 (delimiter J then K, leftmost bit received first). `rx_dv` rises with the first data nibble after K.
- R7: Data code groups, first-received bit leftmost, decode as follows: 11110=0, 01001=1, 10100=2, 10101=3, 01010=4, 01011=5, 01110=6, 01111=7, 10010=8, 10011=9, 10110=A, 10111=B, 11010=C, 11011=D, 11100=E, 11101=F.
- R8: Each decoded group in a frame gives a one-cycle `rx_nib_valid` pulse with `rx_dv` high. `rxd` and `rx_er` hold their values until the next pulse. Nibbles come out in the order they were received.
- R9: The end delimiter 01101 lowers `rx_dv` without producing a nibble. The group after it is consumed unchecked, and the block then returns to hunt. A following J/K may start a new frame directly.
- R10: Any other group inside a frame is an error nibble. It gives `rx_er`=1 and `rxd`=0 with `rx_dv` kept high, and the frame continues. A J/K pair inside a frame does not realign the frame.
- R11: Cycles with `sym_valid` low do not advance any stage, whatever `sym_level` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Bit strobe: `sym_level` holds a new symbol |
| sym_level | input | 2 | Received three-level line symbol |
| rx_dv | output | 1 | Receive data valid, high for the whole frame |
| rxd | output | 4 | Receive nibble |
| rx_er | output | 1 | Current nibble came from an invalid code group |
| rx_nib_valid | output | 1 | One-cycle pulse per new nibble |

## Verification
The delimiter matcher and the in-frame group decoder both see the same bit when a J/K pair appears on a group boundary inside a frame. The bench provokes this by inserting J and K, together with the code groups 00000, 00111 and 11111, between the data groups of a frame. The scoreboard then expects exactly one error nibble for each inserted group, followed by the remaining data nibbles in order. A realignment would shift every later nibble, and the comparison would report it. Back-to-back frames, joined only by the end delimiter, also exercise end detection and the restart of the hunt on adjacent groups.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;

  localparam int GRP_W = 5;
  localparam int NIB_W = 4;

  localparam logic [GRP_W-1:0] CG_J = 5'b11000;
  localparam logic [GRP_W-1:0] CG_K = 5'b10001;
  localparam logic [GRP_W-1:0] CG_T = 5'b01101;

  typedef struct packed {
    logic             ok;
    logic [NIB_W-1:0] nib;
  } dec_t;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_DATA,
    ST_TAIL
  } frm_st_t;

  function automatic dec_t dec5(input logic [GRP_W-1:0] g);
    dec_t r;
    r = '{ok: 1'b1, nib: 4'h0};
    case (g)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      default:  r.ok  = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fe_line_decode.sv
module fe_line_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [1:0] sym_level,
  output logic       bit_o,
  output logic       bvld_o
);

  logic [1:0] lvl_n, lvl_q, lvl_d;
  logic       nrzi_q, nrzi_d;
  logic       chg, nrz;
  logic       bit_q, bit_d;
  logic       vld_q;

  // 2'b10 is folded onto the zero level
  always_comb begin
    lvl_n  = (sym_level == 2'b10) ? 2'b00 : sym_level;
    chg    = (lvl_n != lvl_q);
    nrz    = chg ^ nrzi_q;
    lvl_d  = lvl_q;
    nrzi_d = nrzi_q;
    bit_d  = bit_q;
    if (sym_valid) begin
      lvl_d  = lvl_n;
      nrzi_d = chg;
      bit_d  = nrz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 2'b00;
      nrzi_q <= 1'b0;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      nrzi_q <= nrzi_d;
      bit_q  <= bit_d;
      vld_q  <= sym_valid;
    end
  end

  assign bit_o  = bit_q;
  assign bvld_o = vld_q;

  // R11: a cycle without a strobe yields no bit and keeps the line state
  a_r11_no_strobe_no_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> (!bvld_o && $stable(lvl_q) && $stable(nrzi_q)));

endmodule

// File: rtl/fe_descrambler.sv
module fe_descrambler #(
  parameter int LFSR_W    = 11,
  parameter int SCR_TAP   = 9,
  parameter int LOCK_RUN  = 60,
  parameter int LOSS_BITS = 250000,
  parameter int IDLE_RUN  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic bvld_i,
  output logic plain_o,
  output logic pvld_o,
  output logic lock_o
);

  localparam int RUN_W  = $clog2(LOCK_RUN);
  localparam int TMO_W  = $clog2(LOSS_BITS);
  localparam int ONES_W = $clog2(IDLE_RUN + 1);

  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic              lock_q, lock_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic              pbit_q, pbit_d;
  logic              pvld_q, pvld_d;
  logic              pred, obs, plain_c, idle_hit;

  always_comb begin
    lfsr_d   = lfsr_q;
    lock_d   = lock_q;
    run_d    = run_q;
    tmo_d    = tmo_q;
    ones_d   = ones_q;
    pbit_d   = pbit_q;
    pvld_d   = 1'b0;
    pred     = lfsr_q[LFSR_W-1] ^ lfsr_q[SCR_TAP-1];
    obs      = ~bit_i;
    plain_c  = bit_i ^ pred;
    idle_hit = plain_c && (ones_q >= ONES_W'(IDLE_RUN - 1));
    if (bvld_i) begin
      if (!lock_q) begin
        // training: idle is all ones, so the inverted bit is the keystream
        lfsr_d = {lfsr_q[LFSR_W-2:0], obs};
        tmo_d  = '0;
        ones_d = '0;
        if (obs == pred) begin
          if (run_q == RUN_W'(LOCK_RUN - 1)) begin
            lock_d = 1'b1;
            run_d  = '0;
          end else begin
            run_d = run_q + RUN_W'(1);
          end
        end else begin
          run_d = '0;
        end
      end else begin
        lfsr_d = {lfsr_q[LFSR_W-2:0], pred};
        pbit_d = plain_c;
        pvld_d = 1'b1;
        if (plain_c) begin
          if (ones_q != ONES_W'(IDLE_RUN)) ones_d = ones_q + ONES_W'(1);
        end else begin
          ones_d = '0;
        end
        if (idle_hit) begin
          tmo_d = '0;
        end else if (tmo_q == TMO_W'(LOSS_BITS - 1)) begin
          lock_d = 1'b0;
          tmo_d  = '0;
        end else begin
          tmo_d = tmo_q + TMO_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= '0;
      lock_q <= 1'b0;
      run_q  <= '0;
      tmo_q  <= '0;
      ones_q <= '0;
      pbit_q <= 1'b0;
      pvld_q <= 1'b0;
    end else begin
      lfsr_q <= lfsr_d;
      lock_q <= lock_d;
      run_q  <= run_d;
      tmo_q  <= tmo_d;
      ones_q <= ones_d;
      pbit_q <= pbit_d;
      pvld_q <= pvld_d;
    end
  end

  assign plain_o = pbit_q;
  assign pvld_o  = pvld_q;
  assign lock_o  = lock_q;

  // R4: lock only after a full run of correct predictions
  a_r4_lock_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(run_q) == RUN_W'(LOCK_RUN - 1)));

  // R4: no unscrambled bit leaves while unlocked
  a_r4_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !pvld_q);

  // R5: lock drops only when the idle timeout expires
  a_r5_drop_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> ($past(tmo_q) == TMO_W'(LOSS_BITS - 1)));

endmodule

// File: rtl/fe_group_align.sv
module fe_group_align
  import fe_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic             bvld_i,
  input  logic             lock_i,
  output logic             dv_o,
  output logic [NIB_W-1:0] rxd_o,
  output logic             er_o,
  output logic             stb_o
);

  localparam int WIN_W = 2 * GRP_W;
  localparam int CNT_W = $clog2(GRP_W);

  frm_st_t            st_q, st_d;
  logic [WIN_W-2:0]   win_q, win_d;
  logic [WIN_W-1:0]   win_nx;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               dv_q, dv_d;
  logic               er_q, er_d;
  logic               stb_q, stb_d;
  logic [NIB_W-1:0]   rxd_q, rxd_d;
  dec_t               grp;

  always_comb begin
    st_d   = st_q;
    win_d  = win_q;
    cnt_d  = cnt_q;
    dv_d   = dv_q;
    er_d   = er_q;
    rxd_d  = rxd_q;
    stb_d  = 1'b0;
    win_nx = {win_q, bit_i};
    grp    = dec5(win_nx[GRP_W-1:0]);
    if (!lock_i) begin
      st_d  = ST_HUNT;
      win_d = '0;
      cnt_d = '0;
      dv_d  = 1'b0;
      er_d  = 1'b0;
    end else if (bvld_i) begin
      win_d = win_nx[WIN_W-2:0];
      case (st_q)
        ST_HUNT: begin
          if (win_nx == {CG_J, CG_K}) begin
            st_d  = ST_DATA;
            cnt_d = '0;
          end
        end
        ST_DATA, ST_TAIL: begin
          if (cnt_q == CNT_W'(GRP_W - 1)) begin
            cnt_d = '0;
            if (st_q == ST_TAIL) begin
              st_d = ST_HUNT;
            end else if (win_nx[GRP_W-1:0] == CG_T) begin
              st_d = ST_TAIL;
              dv_d = 1'b0;
              er_d = 1'b0;
            end else begin
              dv_d  = 1'b1;
              stb_d = 1'b1;
              er_d  = !grp.ok;
              rxd_d = grp.ok ? grp.nib : '0;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      win_q <= '0;
      cnt_q <= '0;
      dv_q  <= 1'b0;
      er_q  <= 1'b0;
      rxd_q <= '0;
      stb_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      win_q <= win_d;
      cnt_q <= cnt_d;
      dv_q  <= dv_d;
      er_q  <= er_d;
      rxd_q <= rxd_d;
      stb_q <= stb_d;
    end
  end

  assign dv_o  = dv_q;
  assign rxd_o = rxd_q;
  assign er_o  = er_q;
  assign stb_o = stb_q;

  // R4: losing lock closes any frame on the next cycle
  a_r4_no_dv_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> !dv_q);

  // R8: a nibble pulse always comes inside a frame
  a_r8_stb_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> dv_q);

  // R11: nibble value holds when no bit arrives
  a_r11_hold_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    !bvld_i |=> ($stable(rxd_q) && !stb_q));

  // R10: an error flag is only raised inside a frame
  a_r10_er_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    er_q |-> dv_q);

  // R9: the end delimiter lowers rx_dv without a nibble
  a_r9_end_no_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dv_q) |-> !stb_q);

endmodule

// File: rtl/fe_rx_decoder.sv
module fe_rx_decoder #(
  parameter int LFSR_W    = 11,
  parameter int SCR_TAP   = 9,
  parameter int LOCK_RUN  = 60,
  parameter int LOSS_BITS = 250000,
  parameter int IDLE_RUN  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [1:0] sym_level,
  output logic       rx_dv,
  output logic [3:0] rxd,
  output logic       rx_er,
  output logic       rx_nib_valid
);

  logic [1:0] rs_q;
  logic       rst_n_s;
  logic       nrz_bit, nrz_vld;
  logic       pl_bit, pl_vld, locked;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  fe_line_decode u_line (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sym_valid (sym_valid),
    .sym_level (sym_level),
    .bit_o     (nrz_bit),
    .bvld_o    (nrz_vld)
  );

  fe_descrambler #(
    .LFSR_W    (LFSR_W),
    .SCR_TAP   (SCR_TAP),
    .LOCK_RUN  (LOCK_RUN),
    .LOSS_BITS (LOSS_BITS),
    .IDLE_RUN  (IDLE_RUN)
  ) u_descr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .bit_i   (nrz_bit),
    .bvld_i  (nrz_vld),
    .plain_o (pl_bit),
    .pvld_o  (pl_vld),
    .lock_o  (locked)
  );

  fe_group_align u_align (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .bit_i  (pl_bit),
    .bvld_i (pl_vld),
    .lock_i (locked),
    .dv_o   (rx_dv),
    .rxd_o  (rxd),
    .er_o   (rx_er),
    .stb_o  (rx_nib_valid)
  );

endmodule

// File: tb/fe_rx_decoder_bench.sv
`timescale 1ns/1ps
module fe_rx_decoder_bench;

  localparam int LOSS = 3000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sym_valid;
  logic [1:0] sym_level;
  logic       rx_dv, rx_er, rx_nib_valid;
  logic [3:0] rxd;

  always #4 clk = ~clk;

  fe_rx_decoder #(.LOSS_BITS(LOSS)) u_fe_rx_decoder (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_valid    (sym_valid),
    .sym_level    (sym_level),
    .rx_dv        (rx_dv),
    .rxd          (rxd),
    .rx_er        (rx_er),
    .rx_nib_valid (rx_nib_valid)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  int         frames_seen = 0;
  int         frames_exp = 0;
  bit         done = 0;
  bit         mon_on = 0;
  logic [4:0] exp_q[$];
  logic [7:0] fq[$];

  logic [10:0] tx_ks;
  logic        tx_nrzi;
  logic [1:0]  tx_idx;
  logic        zero_alt;
  int          bitn;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001;
      4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011;
      4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011;
      4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  // transmit model: scramble, NRZI, three-level line (R2, R3, R11)
  task automatic send_bit(input logic p);
    logic k, s;
    if (bitn % 7 == 6) begin
      @(negedge clk);
      sym_valid = 1'b0;
      sym_level = (sym_level == 2'b01) ? 2'b11 : 2'b01;
    end
    k       = tx_ks[10] ^ tx_ks[8];
    tx_ks   = {tx_ks[9:0], k};
    s       = p ^ k;
    tx_nrzi = tx_nrzi ^ s;
    if (tx_nrzi) tx_idx = tx_idx + 2'd1;
    @(negedge clk);
    sym_valid = 1'b1;
    case (tx_idx)
      2'd1: sym_level = 2'b01;
      2'd3: sym_level = 2'b11;
      default: begin
        zero_alt  = ~zero_alt;
        sym_level = zero_alt ? 2'b10 : 2'b00;
      end
    endcase
    bitn++;
  endtask

  task automatic send_group(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_pat(input int n);
    for (int i = 0; i < n; i++) send_bit((i % 4) < 2);
  endtask

  task automatic send_err(input logic [4:0] g, input bit push);
    send_group(g);
    if (push) exp_q.push_back(5'b10000);
  endtask

  task automatic send_frame(input bit push, input int err_at);
    send_group(5'b11000);
    send_group(5'b10001);
    for (int i = 0; i < fq.size(); i++) begin
      if (i == err_at) begin
        send_err(5'b11000, push);
        send_err(5'b10001, push);
        send_err(5'b00000, push);
        send_err(5'b00111, push);
        send_err(5'b11111, push);
      end
      send_group(enc(fq[i][3:0]));
      if (push) exp_q.push_back({1'b0, fq[i][3:0]});
      send_group(enc(fq[i][7:4]));
      if (push) exp_q.push_back({1'b0, fq[i][7:4]});
    end
    send_group(5'b01101);
    send_group(5'b00111);
    if (push) frames_exp++;
  endtask

  task automatic checkpoint(input string req);
    chk(frames_seen == frames_exp, {req, " frame count"}, frames_seen, frames_exp);
    chk(exp_q.size() == 0, {req, " nibbles outstanding"}, exp_q.size(), 0);
  endtask

  // scoreboard monitor
  initial begin
    logic dv_last;
    logic [4:0] e;
    dv_last = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (rx_nib_valid) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4/R6 unexpected nibble", {rx_er, rxd}, 0);
          end else begin
            e = exp_q.pop_front();
            // R7 R8 R10: value, error flag and frame flag of each nibble
            chk(rx_dv && (rxd == e[3:0]) && (rx_er == e[4]), "R7/R8/R10 nibble",
                {rx_dv, rx_er, rxd}, {1'b1, e});
          end
        end
        if (dv_last && !rx_dv) frames_seen++;
        dv_last = rx_dv;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    sym_valid = 1'b0;
    sym_level = 2'b00;
    tx_ks     = 11'h5A3;
    tx_nrzi   = 1'b0;
    tx_idx    = 2'd0;
    zero_alt  = 1'b0;
    bitn      = 0;
    repeat (4) @(negedge clk);
    chk(rx_dv == 1'b0, "R1 rx_dv in reset", rx_dv, 0);
    chk(rx_er == 1'b0, "R1 rx_er in reset", rx_er, 0);
    chk(rx_nib_valid == 1'b0, "R1 rx_nib_valid in reset", rx_nib_valid, 0);
    chk(rxd == 4'h0, "R1 rxd in reset", rxd, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1;

    // R4: a frame before lock is not decoded
    send_idle(10);
    fq = '{8'h55, 8'hD5};
    send_frame(1'b0, -1);
    send_idle(150);
    checkpoint("R4 pre-lock");
    chk(rx_dv == 1'b0 && rxd == 4'h0, "R1 idle after reset", {rx_dv, rxd}, 0);

    // R2 R3 R7 R8 R11: every nibble value, low nibble first
    fq = '{8'h10, 8'h32, 8'h54, 8'h76, 8'h98, 8'hBA, 8'hDC, 8'hFE};
    send_frame(1'b1, -1);
    send_idle(60);
    checkpoint("R2/R3/R7/R11 all codes");

    // R6 R9: back-to-back frames joined by the end delimiter only
    fq = '{8'hA5, 8'h3C};
    send_frame(1'b1, -1);
    fq = '{8'h0F, 8'hF0, 8'h81};
    send_frame(1'b1, -1);
    send_idle(60);
    checkpoint("R9 back-to-back");
    chk(rx_dv == 1'b0, "R9 rx_dv low after end", rx_dv, 0);

    // R10: J, K and invalid groups inside a frame
    fq = '{8'h11, 8'h22, 8'h33};
    send_frame(1'b1, 1);
    send_idle(60);
    checkpoint("R10 in-frame errors");

    // R5 control: long non-idle stretch shorter than the timeout
    send_idle(40);
    send_pat(1500);
    fq = '{8'hC3};
    send_frame(1'b1, -1);
    send_idle(60);
    checkpoint("R5 lock kept");

    // R5: stretch longer than the timeout drops lock
    send_pat(3500);
    send_idle(8);
    fq = '{8'h77, 8'h88};
    send_frame(1'b0, -1);
    send_idle(200);
    checkpoint("R5 lock lost");

    // R5: relock from idle, decoding resumes
    fq = '{8'hE1, 8'h2D};
    send_frame(1'b1, -1);
    send_idle(60);
    @(negedge clk);
    sym_valid = 1'b0;
    repeat (10) @(negedge clk);
    checkpoint("R5 relocked");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule